// File: doc/BRIEF.md
# Recursive Vedic Significand Multiplier

This block is a purely combinational unsigned multiplier that takes two 24-bit significands and returns their full 48-bit product. It is meant to sit inside a single-precision floating-point multiply, where the surrounding logic handles the signs and the exponents. This block only forms the product of the two significands, including their hidden leading ones. It does no rounding and has no pipeline stage.

The product is built as a recursive tree of multipliers:

- The leaves are 3x3 cells. Each cell forms its six product bits column by column, combining the vertical and cross AND terms of that column with the carries from the column below.
- Each node above the leaves splits both operands into a low half and a high half and forms the four half-width sub-products.
- The node adds the two cross sub-products with a ripple-carry adder. It keeps the carry out of that sum.
- A second ripple-carry adder adds that cross sum, carry included, into the upper part of the concatenation of the high-by-high and low-by-low sub-products.
- The low half-width bits of the low-by-low sub-product pass straight to the result with no addition.

With the default width the tree runs through 3, 6, 12 and 24 bits.

Top module: `vedic_sig_mul`

## Requirements
- R1: For every pair of 24-bit unsigned operands, the 48-bit output equals the exact unsigned product of the two operands.
- R2: When either operand is zero, the output is zero.
- R3: When one operand is 1, the output equals the other operand, zero-extended to 48 bits.
- R4: The output does not change when the two operands are exchanged.
- R5: Output bits [11:0] equal bits [11:0] of the product of the two operands' bits [11:0]. Operand bits [23:12] have no effect on them.
- R6: With both operands all ones (0xFFFFFF), the output is 0xFFFFFE000001.
- R7: When one operand is 2^k (k from 0 to 23), the output equals the other operand shifted left by k.
- R8: For operands below 8, where only the 3x3 base cell carries nonzero terms, the output equals the exact product.
- R9: The block is combinational. The output reflects new operand values with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 24 | First unsigned operand (multiplicand significand) |
| b_i | input | 24 | Second unsigned operand (multiplier significand) |
| prod_o | output | 48 | Unsigned product a_i * b_i |

## Verification
At every level of the tree, two carries can arrive together:

- the carry out of the sum of the two cross sub-products;
- the carry that propagates out of the upper half of the low-by-low sub-product into the high-by-high bits.

Both carries must land in the same upper addition without being lost or counted twice. All-ones operands, and random operands whose halves are mostly ones, provoke this case. Each output is judged against a product computed in the bench at full 48-bit width.

Operands below 8 and single-bit operands isolate the base cell and the pure shift paths. Swapping the operands checks that the tree treats its two inputs symmetrically.

// File: rtl/vedic_pkg.sv
package vedic_pkg;
  localparam int unsigned BASE_W = 3;
  localparam int unsigned SIG_W  = 24;

  // true when w is BASE_W times a power of two
  function automatic bit width_ok(int unsigned w);
    int unsigned q;
    if (w < BASE_W || (w % BASE_W) != 0) return 1'b0;
    q = w / BASE_W;
    return (q & (q - 1)) == 0;
  endfunction
endpackage

// File: rtl/vedic_rca.sv
module vedic_rca #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] s_o
);
  logic [W-1:0] c;
  assign c[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s_o[i] = a_i[i] ^ b_i[i] ^ c[i];
    if (i < W - 1) begin : g_carry
      assign c[i+1] = (a_i[i] & b_i[i]) | (c[i] & (a_i[i] ^ b_i[i]));
    end
  end
endmodule

// File: rtl/vedic_cell3.sv
module vedic_cell3 (
  input  logic [2:0] a_i,
  input  logic [2:0] b_i,
  output logic [5:0] p_o
);
  logic       t00, t01, t10, t02, t20, t11, t12, t21, t22;
  logic [1:0] col1;
  logic [2:0] col2, col3;
  logic [1:0] col4;

  assign t00 = a_i[0] & b_i[0];
  assign t01 = a_i[0] & b_i[1];
  assign t10 = a_i[1] & b_i[0];
  assign t02 = a_i[0] & b_i[2];
  assign t20 = a_i[2] & b_i[0];
  assign t11 = a_i[1] & b_i[1];
  assign t12 = a_i[1] & b_i[2];
  assign t21 = a_i[2] & b_i[1];
  assign t22 = a_i[2] & b_i[2];

  // column sums; bits above bit 0 are carries into the next column
  assign col1 = {1'b0, t01} + {1'b0, t10};
  assign col2 = {2'b0, t02} + {2'b0, t20} + {2'b0, t11} + {2'b0, col1[1]};
  assign col3 = {2'b0, t12} + {2'b0, t21} + {1'b0, col2[2:1]};
  assign col4 = {1'b0, t22} + col3[2:1];

  assign p_o = {col4, col3[0], col2[0], col1[0], t00};
endmodule

// File: rtl/vedic_node.sv
module vedic_node #(
  parameter int unsigned W = 24
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  import vedic_pkg::*;

  localparam int unsigned H = W / 2;

  if (W == BASE_W) begin : g_leaf
    vedic_cell3 i_cell (
      .a_i(a_i),
      .b_i(b_i),
      .p_o(p_o)
    );
  end else begin : g_split
    logic [2*H-1:0] p_ll, p_hl, p_lh, p_hh;
    logic [2*H:0]   mid;
    logic [3*H-1:0] upper;

    vedic_node #(.W(H)) i_ll (.a_i(a_i[H-1:0]), .b_i(b_i[H-1:0]), .p_o(p_ll));
    vedic_node #(.W(H)) i_hl (.a_i(a_i[W-1:H]), .b_i(b_i[H-1:0]), .p_o(p_hl));
    vedic_node #(.W(H)) i_lh (.a_i(a_i[H-1:0]), .b_i(b_i[W-1:H]), .p_o(p_lh));
    vedic_node #(.W(H)) i_hh (.a_i(a_i[W-1:H]), .b_i(b_i[W-1:H]), .p_o(p_hh));

    // cross terms; the top bit is the carry of the middle sum
    vedic_rca #(.W(2*H+1)) i_mid (
      .a_i({1'b0, p_hl}),
      .b_i({1'b0, p_lh}),
      .s_o(mid)
    );

    // upper 3H bits; cannot overflow since the full product fits 2W bits
    vedic_rca #(.W(3*H)) i_up (
      .a_i({p_hh, p_ll[2*H-1:H]}),
      .b_i({{(H-1){1'b0}}, mid}),
      .s_o(upper)
    );

    assign p_o = {upper, p_ll[H-1:0]};
  end
endmodule

// File: rtl/vedic_sig_mul.sv
module vedic_sig_mul #(
  parameter int unsigned SIG_W = vedic_pkg::SIG_W
) (
  input  logic [SIG_W-1:0]   a_i,
  input  logic [SIG_W-1:0]   b_i,
  output logic [2*SIG_W-1:0] prod_o
);
  initial begin
    if (!vedic_pkg::width_ok(SIG_W))
      $fatal(1, "SIG_W must be 3 times a power of two");
  end

  vedic_node #(.W(SIG_W)) i_root (
    .a_i(a_i),
    .b_i(b_i),
    .p_o(prod_o)
  );
endmodule

// File: rtl/vedic_sig_mul_chk.sv
module vedic_sig_mul_chk #(
  parameter int unsigned SIG_W = 24
) (
  input logic [SIG_W-1:0]   a_i,
  input logic [SIG_W-1:0]   b_i,
  input logic [2*SIG_W-1:0] prod_o
);
  localparam int unsigned H = SIG_W / 2;

  logic [2*SIG_W-1:0] ref_prod;
  logic [2*H-1:0]     low_prod;

  assign ref_prod = {{SIG_W{1'b0}}, a_i} * {{SIG_W{1'b0}}, b_i};
  assign low_prod = {{H{1'b0}}, a_i[H-1:0]} * {{H{1'b0}}, b_i[H-1:0]};

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      // R1
      exact_prod_chk: assert (prod_o == ref_prod);
      // R2
      zero_operand_chk: assert (!(a_i == '0 || b_i == '0) || prod_o == '0);
      // R3
      unit_operand_chk: assert (a_i != SIG_W'(1) || prod_o == {{SIG_W{1'b0}}, b_i});
      // R5
      low_bits_chk: assert (prod_o[H-1:0] == low_prod[H-1:0]);
    end
  end
endmodule

bind vedic_sig_mul vedic_sig_mul_chk #(.SIG_W(SIG_W)) i_vedic_sig_mul_chk (
  .a_i(a_i),
  .b_i(b_i),
  .prod_o(prod_o)
);

// File: tb/test_vedic_sig_mul.sv
module test_vedic_sig_mul;
  localparam int unsigned W = 24;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic [W-1:0]    a, b;
  logic [2*W-1:0]  prod;
  int              total = 0;
  int              bad = 0;
  bit              done = 1'b0;

  always #4 clk = ~clk;

  vedic_sig_mul i_vedic_sig_mul (
    .a_i(a),
    .b_i(b),
    .prod_o(prod)
  );

  function automatic logic [2*W-1:0] exp_mul(logic [W-1:0] x, logic [W-1:0] y);
    return {{W{1'b0}}, x} * {{W{1'b0}}, y};
  endfunction

  task automatic check(string req, logic [2*W-1:0] exp);
    total++;
    if (prod !== exp) begin
      bad++;
      $display("FAIL %s a=%h b=%h got=%h exp=%h", req, a, b, prod, exp);
    end
  endtask

  // drive at falling edge, sample mid low phase
  task automatic apply(logic [W-1:0] x, logic [W-1:0] y);
    @(negedge clk);
    a = x;
    b = y;
    #2;
  endtask

  initial begin
    int unsigned seed;
    logic [2*W-1:0] p1;
    seed = 32'd1234;
    void'($urandom(seed));
    a = '0;
    b = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // reset-time state: zero operands give zero (R2)
    #1;
    check("R2", '0);

    apply('0, 24'hABCDEF);   check("R2", '0);
    apply(24'h123456, '0);   check("R2", '0);
    apply(24'h1, 24'h9A5C3E); check("R3", {24'h0, 24'h9A5C3E});
    apply(24'h7F00FF, 24'h1); check("R3", {24'h0, 24'h7F00FF});
    apply('1, '1);           check("R6", 48'hFFFFFE000001);
    apply('1, '1);           check("R1", exp_mul('1, '1));

    for (int k = 0; k < W; k++) begin
      logic [W-1:0] v;
      v = W'($urandom);
      apply(W'(1) << k, v);
      check("R7", {{W{1'b0}}, v} << k);
    end

    for (int x = 0; x < 8; x++)
      for (int y = 0; y < 8; y++) begin
        apply(W'(x), W'(y));
        check("R8", 48'(x * y));
      end

    // R5: upper operand halves must not disturb bits [11:0]
    for (int n = 0; n < 50; n++) begin
      logic [11:0] lx, ly;
      logic [23:0] lp;
      lx = 12'($urandom);
      ly = 12'($urandom);
      lp = {12'h0, lx} * {12'h0, ly};
      apply({12'($urandom), lx}, {12'($urandom), ly});
      total++;
      if (prod[11:0] !== lp[11:0]) begin
        bad++;
        $display("FAIL R5 got=%h exp=%h", prod[11:0], lp[11:0]);
      end
    end

    // R4: swap operands
    for (int n = 0; n < 50; n++) begin
      logic [W-1:0] x, y;
      x = W'($urandom);
      y = W'($urandom);
      apply(x, y);
      p1 = prod;
      apply(y, x);
      check("R4", p1);
    end

    // R9: output follows operands with no clock edge between changes
    a = 24'h00F00D; b = 24'h000BAD; #1; check("R9", exp_mul(24'h00F00D, 24'h000BAD));
    a = 24'hC0FFEE; #1;               check("R9", exp_mul(24'hC0FFEE, 24'h000BAD));

    // R1: random, dense-ones and sparse patterns
    for (int n = 0; n < 3000; n++) begin
      logic [W-1:0] x, y;
      x = W'($urandom);
      y = W'($urandom);
      case (n % 3)
        1: begin x = x | W'($urandom); y = y | W'($urandom); end
        2: begin x = x & W'($urandom); y = y | 24'hFFF000; end
        default: ;
      endcase
      apply(x, y);
      check("R1", exp_mul(x, y));
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule